// File: doc/BRIEF.md
# Frequency trim pulse generator

This block produces the sparse correction requests that pull a time-of-day counter onto the right rate. Each request asks the counter to add or drop one nanosecond. The counter itself sits outside the block. Software picks the spacing between requests and writes it into a configuration register. The spacing is a 30-bit value, and a unit bit says whether it is counted in picoseconds or in nanoseconds. A control register holds an enable bit and a direction bit, which say whether corrections run and whether each one slows the clock down or speeds it up.

While corrections are enabled, the block adds the reference clock period, given in picoseconds as a parameter, to an accumulator on every cycle. When the accumulated time reaches the programmed spacing, the block raises a one-cycle pulse together with a sign bit. It then subtracts the spacing and keeps the remainder, so a spacing that is not a whole number of clock periods still gives the right average rate. Turning the programmed rate from a ppm figure into a spacing is left to software.

Top module: `freqtrim_gen`

## Requirements
- R1: After reset, corrections are disabled, the threshold is zero and both outputs are low; no pulse appears until the control register is written with the enable bit (`ctlEnable`) set to 1.
- R2: A configuration write (`cfgWr` high for one cycle) loads a threshold. With `cfgUnitNs` = 0 the threshold is `cfgInterval` picoseconds. With `cfgUnitNs` = 1 it is `cfgInterval` × 1000 picoseconds. The threshold is used from the next edge on.
- R3: While enabled, each rising edge adds `CLK_PERIOD_PS` to the accumulator. When the sum reaches or passes the threshold, `trimPulse` is high for the one cycle after that edge and the remainder (sum minus threshold) is kept. With a 10 ns clock, a 30000 ps spacing gives one pulse every 3 cycles, and 25000 ps gives 2 pulses every 5 cycles.
- R4: In nanosecond units, a spacing of 25 gives the same pulse train as 25000 ps, and a spacing of 40 gives one pulse every 4 cycles of 10 ns.
- R5: If the remainder after a pulse is still not below the threshold, it is dropped to zero. A spacing at or below one clock period, including zero, therefore gives a pulse on every enabled cycle and never more than one.
- R6: `trimRetard` is high exactly when `trimPulse` is high and the direction in force at that edge is 1 (1 = slow the counter, 0 = speed it up). `trimRetard` is low whenever there is no pulse.
- R7: A control write with `ctlEnable` = 0 takes effect at the edge where it is written. No pulse follows that edge or any later edge until corrections are enabled again, and the accumulator is cleared.
- R8: A configuration write clears the accumulator at its edge, and no pulse follows that edge. Counting toward the next pulse restarts from zero, so with a 30000 ps spacing the next pulse comes 3 edges after the write.
- R9: A control write that keeps `ctlEnable` = 1 does not clear the accumulator. Its direction applies to a pulse produced at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Synchronous active-low reset |
| cfgWr | input | 1 | Configuration register write strobe |
| cfgInterval | input | 30 | Spacing between corrections |
| cfgUnitNs | input | 1 | Unit of the spacing: 0 = ps, 1 = ns |
| ctlWr | input | 1 | Control register write strobe |
| ctlEnable | input | 1 | Enable for correction requests |
| ctlRetard | input | 1 | Direction: 1 = slow down, 0 = speed up |
| trimPulse | output | 1 | One-cycle correction request |
| trimRetard | output | 1 | Sign of the current request |

## Verification
The spacing is tried with a whole multiple of the clock period (30000 ps), a fractional multiple (25000 ps), the same value written in nanoseconds (25), and a spacing exactly equal to the period and zero. Together these separate correct remainder handling from a counter that resets on each pulse, ns scaling from ps, and saturation at one pulse per cycle. Disable, configuration writes and direction changes are applied in the middle of a run. This shows whether the accumulator is cleared or kept at the exact edge, and which direction a pulse carries. A behavioural model compares both outputs on every cycle.

// File: rtl/freqtrim_pkg.sv
package freqtrim_pkg;

  // Strobes passed from the control half to the datapath each cycle.
  typedef struct packed {
    logic loadCfg;  // capture a new threshold
    logic clrAcc;   // zero the accumulator this edge
    logic run;      // accumulate and compare this edge
    logic retard;   // direction in force at this edge
  } trimStb_t;

endpackage

// File: rtl/freqtrim_ctrl.sv
module freqtrim_ctrl
  import freqtrim_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cfgWr,
  input  logic     ctlWr,
  input  logic     ctlEnable,
  input  logic     ctlRetard,
  output trimStb_t stb,
  output logic     dirState
);

  logic enState;
  logic effEnable;
  logic effRetard;

  // A control write acts at its own edge rather than one cycle later.
  assign effEnable = ctlWr ? ctlEnable : enState;
  assign effRetard = ctlWr ? ctlRetard : dirState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enState  <= 1'b0;
      dirState <= 1'b0;
    end else if (ctlWr) begin
      enState  <= ctlEnable;
      dirState <= ctlRetard;
    end
  end

  always_comb begin
    stb.loadCfg = cfgWr;
    stb.clrAcc  = cfgWr || !effEnable;
    stb.run     = effEnable && !cfgWr;
    stb.retard  = effRetard;
  end

endmodule

// File: rtl/freqtrim_dp.sv
module freqtrim_dp
  import freqtrim_pkg::*;
#(
  parameter int INTERVAL_W    = 30,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int NS_SCALE      = 1000,
  localparam int THR_W        = INTERVAL_W + $clog2(NS_SCALE),
  localparam int SUM_W        = THR_W + 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  trimStb_t              stb,
  input  logic [INTERVAL_W-1:0] cfgInterval,
  input  logic                  cfgUnitNs,
  output logic                  trimPulse,
  output logic                  trimRetard,
  output logic [THR_W-1:0]      accVal,
  output logic [THR_W-1:0]      thrVal
);

  localparam logic [SUM_W-1:0] STEP = SUM_W'(CLK_PERIOD_PS);

  logic [THR_W-1:0] ivWide;
  logic [THR_W-1:0] thrNew;
  logic [SUM_W-1:0] sum;
  logic [SUM_W-1:0] rem;
  logic [SUM_W-1:0] thrExt;
  logic             hit;
  logic             keepRem;
  logic [THR_W-1:0] accNext;

  // Threshold is held in picoseconds so one comparator serves both units.
  assign ivWide = THR_W'(cfgInterval);
  assign thrNew = cfgUnitNs ? (ivWide * THR_W'(NS_SCALE)) : ivWide;

  assign thrExt  = {1'b0, thrVal};
  assign sum     = {1'b0, accVal} + STEP;
  assign hit     = (sum >= thrExt);
  assign rem     = sum - thrExt;
  assign keepRem = (rem < thrExt);

  always_comb begin
    if (stb.clrAcc || !stb.run) begin
      accNext = '0;
    end else if (hit) begin
      accNext = keepRem ? rem[THR_W-1:0] : '0;
    end else begin
      accNext = sum[THR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      thrVal <= '0;
    end else if (stb.loadCfg) begin
      thrVal <= thrNew;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accVal     <= '0;
      trimPulse  <= 1'b0;
      trimRetard <= 1'b0;
    end else begin
      accVal     <= accNext;
      trimPulse  <= stb.run && hit;
      trimRetard <= stb.run && hit && stb.retard;
    end
  end

endmodule

// File: rtl/freqtrim_gen.sv
module freqtrim_gen
  import freqtrim_pkg::*;
#(
  parameter int INTERVAL_W    = 30,
  parameter int CLK_PERIOD_PS = 10000,
  parameter int NS_SCALE      = 1000,
  localparam int THR_W        = INTERVAL_W + $clog2(NS_SCALE)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgWr,
  input  logic [INTERVAL_W-1:0] cfgInterval,
  input  logic                  cfgUnitNs,
  input  logic                  ctlWr,
  input  logic                  ctlEnable,
  input  logic                  ctlRetard,
  output logic                  trimPulse,
  output logic                  trimRetard
);

  trimStb_t         stb;
  logic             dirState;
  logic [THR_W-1:0] accVal;
  logic [THR_W-1:0] thrVal;

  freqtrim_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWr     (cfgWr),
    .ctlWr     (ctlWr),
    .ctlEnable (ctlEnable),
    .ctlRetard (ctlRetard),
    .stb       (stb),
    .dirState  (dirState)
  );

  freqtrim_dp #(
    .INTERVAL_W    (INTERVAL_W),
    .CLK_PERIOD_PS (CLK_PERIOD_PS),
    .NS_SCALE      (NS_SCALE)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .cfgInterval (cfgInterval),
    .cfgUnitNs   (cfgUnitNs),
    .trimPulse   (trimPulse),
    .trimRetard  (trimRetard),
    .accVal      (accVal),
    .thrVal      (thrVal)
  );

endmodule

// File: rtl/freqtrim_chk.sv
module freqtrim_chk #(
  parameter int THR_W = 40
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWr,
  input logic             ctlWr,
  input logic             ctlEnable,
  input logic             ctlRetard,
  input logic             dirState,
  input logic             trimPulse,
  input logic             trimRetard,
  input logic [THR_W-1:0] accVal,
  input logic [THR_W-1:0] thrVal
);

  // R3 / R5: the kept remainder never reaches the threshold
  p_rem_bounded_r3: assert property (@(posedge clk) disable iff (!rstN)
    (accVal < thrVal) || (accVal == '0));

  // R6: a sign is never reported without a pulse
  p_sign_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    trimRetard |-> trimPulse);

  // R6 / R9: pulse sign matches the direction in force at its edge
  p_sign_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    trimPulse |-> (trimRetard == $past(ctlWr ? ctlRetard : dirState)));

  // R7: a disabling control write yields no pulse
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctlWr && !ctlEnable) |-> !trimPulse);

  // R8: a configuration write yields no pulse at its edge
  p_cfg_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr) |-> !trimPulse);

endmodule

bind freqtrim_gen freqtrim_chk #(.THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .cfgWr      (cfgWr),
  .ctlWr      (ctlWr),
  .ctlEnable  (ctlEnable),
  .ctlRetard  (ctlRetard),
  .dirState   (dirState),
  .trimPulse  (trimPulse),
  .trimRetard (trimRetard),
  .accVal     (accVal),
  .thrVal     (thrVal)
);

// File: tb/tb_freqtrim_gen.sv
`timescale 1ns/1ps
module tb_freqtrim_gen;

  localparam int  IW        = 30;
  localparam int  PERIOD_PS = 10000;
  localparam longint WATCHDOG_CYC = 100000;

  logic          clk = 1'b0;
  logic          rstN;
  logic          cfgWr;
  logic [IW-1:0] cfgInterval;
  logic          cfgUnitNs;
  logic          ctlWr;
  logic          ctlEnable;
  logic          ctlRetard;
  logic          trimPulse;
  logic          trimRetard;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  freqtrim_gen dut (
    .clk         (clk),
    .rstN        (rstN),
    .cfgWr       (cfgWr),
    .cfgInterval (cfgInterval),
    .cfgUnitNs   (cfgUnitNs),
    .ctlWr       (ctlWr),
    .ctlEnable   (ctlEnable),
    .ctlRetard   (ctlRetard),
    .trimPulse   (trimPulse),
    .trimRetard  (trimRetard)
  );

  // Behavioural reference: picosecond bookkeeping with plain integers.
  longint mThr, mAcc;
  bit     mEn, mDir, expP, expS;

  always @(posedge clk) begin
    bit     en, dir;
    longint s;
    if (!rstN) begin
      mThr = 0; mAcc = 0; mEn = 0; mDir = 0; expP = 0; expS = 0;
    end else begin
      en  = ctlWr ? ctlEnable : mEn;
      dir = ctlWr ? ctlRetard : mDir;
      expP = 0;
      if (cfgWr) begin
        mThr = cfgUnitNs ? longint'(cfgInterval) * 1000 : longint'(cfgInterval);
        mAcc = 0;
      end else if (!en) begin
        mAcc = 0;
      end else begin
        s = mAcc + PERIOD_PS;
        if (s >= mThr) begin
          expP = 1;
          s    = s - mThr;
          mAcc = (s >= mThr) ? 0 : s;
        end else begin
          mAcc = s;
        end
      end
      expS = expP && dir;
      mEn  = en;
      mDir = dir;
    end
  end

  task automatic chk(string tag, longint got, longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  // Cycle-by-cycle comparison against the model.
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R3 pulse vs model", trimPulse, expP);
      chk("R6 sign vs model", trimRetard, expS);
    end
  end

  task automatic wrCfg(input int iv, input bit ns);
    cfgWr = 1; cfgInterval = IW'(iv); cfgUnitNs = ns;
    @(negedge clk);
    cfgWr = 0;
  endtask

  task automatic wrCtl(input bit en, input bit dir);
    ctlWr = 1; ctlEnable = en; ctlRetard = dir;
    @(negedge clk);
    ctlWr = 0;
  endtask

  task automatic countWin(input int n, output int np, output int ns);
    np = 0; ns = 0;
    for (int i = 0; i < n; i++) begin
      if (trimPulse)  np++;
      if (trimRetard) ns++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int np, ns, gap;
    rstN = 0; cfgWr = 0; cfgInterval = '0; cfgUnitNs = 0;
    ctlWr = 0; ctlEnable = 0; ctlRetard = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset pulse", trimPulse, 0);
    chk("R1 reset sign", trimRetard, 0);
    rstN = 1;
    countWin(20, np, ns);
    chk("R1 idle after reset", np, 0);

    // R2/R3: 30000 ps -> every third cycle
    wrCfg(30000, 0); wrCtl(1, 0);
    countWin(30, np, ns);
    chk("R3 whole spacing", np, 10);

    // R7: disable mid-run
    wrCtl(0, 0);
    countWin(20, np, ns);
    chk("R7 disabled", np, 0);

    // R3: fractional spacing keeps remainder
    wrCfg(25000, 0); wrCtl(1, 0);
    countWin(50, np, ns);
    chk("R3 remainder kept", np, 20);

    // R4/R6: ns unit, slowing direction
    wrCtl(0, 0); wrCfg(25, 1); wrCtl(1, 1);
    countWin(50, np, ns);
    chk("R4 ns 25", np, 20);
    chk("R6 retard count", ns, 20);

    wrCtl(0, 0); wrCfg(40, 1); wrCtl(1, 0);
    countWin(50, np, ns);
    chk("R4 ns 40", np, 12);
    chk("R6 advance count", ns, 0);

    // R5: spacing equal to period, then zero
    wrCtl(0, 0); wrCfg(10000, 0); wrCtl(1, 0);
    countWin(50, np, ns);
    chk("R5 equal period", np, 50);
    wrCfg(0, 0);
    chk("R8 no pulse at cfg edge", trimPulse, 0);
    @(negedge clk);
    countWin(50, np, ns);
    chk("R5 zero spacing", np, 50);

    // R8: config write restarts counting
    wrCtl(0, 0); wrCfg(30000, 0); wrCtl(1, 0);
    @(negedge clk);
    wrCfg(30000, 0);
    chk("R8 cleared at write", trimPulse, 0);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!trimPulse && gap < 100);
    chk("R8 restart gap", gap, 3);

    // R9: direction change keeps accumulator and applies at its edge
    @(negedge clk);
    @(negedge clk);
    wrCtl(1, 1);
    chk("R9 pulse at ctl edge", trimPulse, 1);
    chk("R9 sign at ctl edge", trimRetard, 1);

    wrCtl(0, 0);
    @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule